// File: doc/BRIEF.md
# Free-Running-Clock SPI Master

This block is an 8-bit serial master for the SPI protocol. Its bit clock comes from a divider of the system clock that runs without pause while the block is enabled in master mode. The divider is not restarted when a transfer is requested. A one-cycle write strobe with a data byte arms a transfer. The frame then starts at the next bit boundary of the running divider, so the start delay depends on where the write fell within the divider period.

During a frame the block drives the serial clock, the serial output and an active-low select, and it samples the serial input. The clock polarity and phase are set at the ports. There are four divide ratios. At the end of the frame the block raises a one-cycle done strobe and presents the received byte.

Top module: `spi_fr_master`

## Requirements
- R1: A frame carries 8 bits, most significant bit first. The bit on `mosi` is valid at every sampling edge of `sck`.
- R2: A frame starts only after a write. Nothing starts while `cfg_en` or `cfg_master` is low, and in that case `ss_n` stays high and `sck` stays at its idle level.
- R3: A frame starts (`ss_n` falls) between 1 and N system cycles after the edge that samples `wr_en`. N is 2, 8, 32 or 128 for `cfg_rate` values 0, 1, 2 and 3.
- R4: `ss_n` stays low for exactly 8·N system cycles per frame and is then released.
- R5: When no frame is running, `sck` sits at the idle level: low for `cfg_cpol`=0 and high for `cfg_cpol`=1.
- R6: In the first cycle with `ss_n` low, `sck` is at the idle level when `cfg_cpha`=0 and at the active level (the inverse of idle) when `cfg_cpha`=1.
- R7: Each frame has exactly 8 transitions of `sck` from idle to active. The input is sampled on the idle-to-active edge when `cfg_cpha`=0 and on the active-to-idle edge when `cfg_cpha`=1.
- R8: `done` is high for exactly one cycle per frame, while `ss_n` is still low. From that cycle on, `rx_data` holds the 8 bits sampled from `miso`, the first sampled bit in bit 7.
- R9: A write made while `busy` is high is ignored. It neither alters the frame in progress nor starts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_master | input | 1 | Master select; must be high with `cfg_en` for the divider to run |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_rate | input | 2 | Divide ratio select: 2, 8, 32, 128 |
| wr_en | input | 1 | One-cycle data write strobe |
| wr_data | input | 8 | Byte to transmit |
| miso | input | 1 | Serial input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer armed or running |
| done | output | 1 | One-cycle end-of-frame strobe |
| rx_data | output | 8 | Last received byte |

## Verification
The hardest case is a write at each possible phase of the running divider, because the start latency depends on a phase that cannot be seen at the ports. The bench places each write after a different number of idle cycles, so the write lands at several offsets within the divider period at every ratio. For each offset it checks that the measured latency stays inside the one-bit window. A second hard case is a write during a frame. The bench injects one partway through a looped-back frame, then confirms that the received byte is unchanged and that no second frame follows.

// File: rtl/spi_fr_pkg.sv
// Shared types and helpers for the free-running SPI master.
// Assumes divide ratios of 2 << (2*rate), i.e. 2, 8, 32, 128.
package spi_fr_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2
    } xfer_state_t;

    // Half a bit time, in system cycles, for a rate select value.
    function automatic logic [DIV_W-1:0] half_len(input logic [1:0] rate);
        return DIV_W'(1) << {rate, 1'b0};
    endfunction

endpackage

// File: rtl/spi_fr_clkdiv.sv
// Free-running bit-clock divider. While run is high it produces a
// mid-bit tick and a bit-boundary tick once per bit time. It is held
// cleared while run is low. Assumes a rate change may happen at any time.
module spi_fr_clkdiv
    import spi_fr_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick_mid,
    output logic       tick_bnd
);
    logic [CNT_W-1:0] cnt;
    logic             second_half;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    // Last count value of the current half period.
    always_comb begin
        half_m1 = CNT_W'(half_len(rate)) - CNT_W'(1);
        wrap    = run && (cnt >= half_m1);
    end

    // Half-period counter and half selector; stopped when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt         <= '0;
            second_half <= 1'b0;
        end else if (wrap) begin
            cnt         <= '0;
            second_half <= ~second_half;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Tick decode: end of first half is mid-bit, end of second is boundary.
    always_comb begin
        tick_mid = wrap && !second_half;
        tick_bnd = wrap &&  second_half;
    end
endmodule

// File: rtl/spi_fr_shifter.sv
// Transmit and receive shift registers. Loads the outgoing byte on a
// write, shifts out on bit boundaries, samples the input on mid-bit
// ticks, and commits the received byte on the last sample.
module spi_fr_shifter
    import spi_fr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift_out,
    input  logic         sample,
    input  logic         commit,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_data
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;

    // Outgoing shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_sh <= '0;
        else if (load)      tx_sh <= load_data;
        else if (shift_out) tx_sh <= {tx_sh[W-2:0], 1'b0};
    end

    // Incoming shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sh <= '0;
        else if (sample) rx_sh <= {rx_sh[W-2:0], miso};
    end

    // Received byte register, updated with the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_data <= '0;
        else if (commit) rx_data <= {rx_sh[W-2:0], miso};
    end

    // Serial output is the head of the transmit register.
    always_comb mosi = tx_sh[W-1];
endmodule

// File: rtl/spi_fr_ctrl.sv
// Frame sequencer. Arms on a write, starts on the next divider boundary,
// drives sck and ss_n per CPOL/CPHA, counts bits and flags completion.
// Assumes tick_mid and tick_bnd alternate and are never high together.
module spi_fr_ctrl
    import spi_fr_pkg::*;
#(
    parameter int W     = DATA_W,
    localparam int BC_W = $clog2(W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cpol,
    input  logic cpha,
    input  logic wr_en,
    input  logic tick_mid,
    input  logic tick_bnd,
    output logic load,
    output logic shift_out,
    output logic sample,
    output logic commit,
    output logic sck,
    output logic ss_n,
    output logic busy,
    output logic done
);
    xfer_state_t      state;
    logic [BC_W-1:0]  bitcnt;
    logic             in_xfer;
    logic             last_bit;
    logic             start;
    logic             finish;

    // Strobes for the shifter and the sequencer itself.
    always_comb begin
        in_xfer   = (state == ST_XFER);
        last_bit  = (bitcnt == BC_W'(W - 1));
        load      = run && (state == ST_IDLE) && wr_en;
        start     = (state == ST_ARMED) && tick_bnd;
        sample    = in_xfer && tick_mid;
        shift_out = in_xfer && tick_bnd && !last_bit;
        finish    = in_xfer && tick_bnd && last_bit;
        commit    = sample && last_bit;
        busy      = (state != ST_IDLE);
    end

    // State, bit counter, select, clock and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            ss_n   <= 1'b1;
            sck    <= rst_n ? cpol : 1'b0;
            done   <= 1'b0;
        end else begin
            done <= commit;
            unique case (state)
                ST_IDLE: begin
                    sck <= cpol;
                    if (wr_en) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    sck <= cpol;
                    if (start) begin
                        state  <= ST_XFER;
                        bitcnt <= '0;
                        ss_n   <= 1'b0;
                        sck    <= cpol ^ cpha;
                    end
                end
                ST_XFER: begin
                    if (tick_mid) begin
                        sck <= cpol ^ ~cpha;
                    end else if (tick_bnd) begin
                        if (last_bit) begin
                            state <= ST_IDLE;
                            ss_n  <= 1'b1;
                            sck   <= cpol;
                        end else begin
                            bitcnt <= bitcnt + BC_W'(1);
                            sck    <= cpol ^ cpha;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_fr_master.sv
// Top of the free-running-clock SPI master: divider, sequencer, shifter.
// Assumes configuration is held steady while a frame is in progress.
module spi_fr_master
    import spi_fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic        cfg_master,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic [1:0]  cfg_rate,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        ss_n,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rx_data
);
    logic run;
    logic tick_mid, tick_bnd;
    logic load, shift_out, sample, commit;

    // Divider and sequencer run only with enable and master both set.
    always_comb run = cfg_en && cfg_master;

    spi_fr_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate     (cfg_rate),
        .tick_mid (tick_mid),
        .tick_bnd (tick_bnd)
    );

    spi_fr_ctrl #(.W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .wr_en     (wr_en),
        .tick_mid  (tick_mid),
        .tick_bnd  (tick_bnd),
        .load      (load),
        .shift_out (shift_out),
        .sample    (sample),
        .commit    (commit),
        .sck       (sck),
        .ss_n      (ss_n),
        .busy      (busy),
        .done      (done)
    );

    spi_fr_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (wr_data),
        .shift_out (shift_out),
        .sample    (sample),
        .commit    (commit),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/spi_fr_master_chk.sv
// Port-level protocol checks for spi_fr_master, bound to every instance.
module spi_fr_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_master,
    input logic cfg_cpol,
    input logic sck,
    input logic ss_n,
    input logic busy,
    input logic wr_en,
    input logic done
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ss_n);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ss_n && $past(ss_n) && $stable(cfg_cpol)
         && $past(!busy)) |-> (sck == cfg_cpol));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && cfg_master) |=> ss_n);

    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && cfg_en && cfg_master) |=> (busy || ss_n));
endmodule

bind spi_fr_master spi_fr_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_master (cfg_master),
    .cfg_cpol   (cfg_cpol),
    .sck        (sck),
    .ss_n       (ss_n),
    .busy       (busy),
    .wr_en      (wr_en),
    .done       (done)
);

// File: tb/spi_fr_master_test.sv
`timescale 1ns/1ps
module spi_fr_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       invert = 1'b0;
    logic       miso;
    logic       sck, mosi, ss_n, busy, done;
    logic [7:0] rx_data;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;

    always #2.5 clk = ~clk;

    assign miso = invert ? ~mosi : mosi;

    spi_fr_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate),
        .wr_en(wr_en), .wr_data(wr_data), .miso(miso), .sck(sck),
        .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done), .rx_data(rx_data)
    );

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One looped-back frame with full timing and protocol checks.
    task automatic run_frame(input bit pol, input bit pha, input logic [1:0] rate,
                             input logic [7:0] tx, input bit inv, input int skew,
                             input bit inject);
        int ratio = 2 << (2 * rate);
        int lat = 0;
        int low = 0;
        int act_edges = 0;
        int dones = 0;
        logic [7:0] cap = 8'h00;
        logic prev;
        @(negedge clk);
        cfg_en = 1'b1; cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha;
        cfg_rate = rate; invert = inv;
        idle(3 + skew);
        check(sck == pol && ss_n, "R5 idle sck", int'(sck), int'(pol));
        wr_en = 1'b1; wr_data = tx;
        @(negedge clk);
        wr_en = 1'b0;
        lat = 1;
        while (ss_n && lat < 400) begin
            @(negedge clk);
            if (ss_n) lat++;
        end
        // R3: start latency inside one bit time.
        check(lat >= 1 && lat <= ratio, "R3 start latency", lat, ratio);
        // R6: first-cycle clock level.
        check(sck == (pol ^ pha), "R6 first half level", int'(sck), int'(pol ^ pha));
        prev = pol;
        while (!ss_n && low < 2000) begin
            low++;
            if (done) dones++;
            if (prev == pol && sck != pol) begin
                act_edges++;
                if (!pha) cap = {cap[6:0], mosi};
            end
            if (prev != pol && sck == pol && pha) cap = {cap[6:0], mosi};
            prev = sck;
            if (inject && low == 5) begin
                wr_en = 1'b1; wr_data = ~tx;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(low == 8 * ratio, "R4 frame length", low, 8 * ratio);
        check(act_edges == 8, "R7 active edges", act_edges, 8);
        check(cap == tx, "R1 mosi msb first", int'(cap), int'(tx));
        check(dones == 1, "R8 done pulses", dones, 1);
        check(rx_data == (inv ? ~tx : tx), "R8 received byte",
              int'(rx_data), int'(inv ? ~tx : tx));
        if (inject) begin
            int extra = 0;
            for (int i = 0; i < 3 * ratio; i++) begin
                @(negedge clk);
                if (!ss_n || busy) extra++;
            end
            check(extra == 0, "R9 write during frame ignored", extra, 0);
        end
    endtask

    task automatic test_reset();
        check(ss_n == 1'b1 && !busy && !done, "R2 reset select high", int'(ss_n), 1);
        check(rx_data == 8'h00, "R8 reset rx", int'(rx_data), 0);
    endtask

    task automatic test_modes();
        run_frame(1'b0, 1'b0, 2'd0, 8'hA5, 1'b0, 0, 1'b0);
        run_frame(1'b0, 1'b1, 2'd0, 8'h3C, 1'b0, 1, 1'b0);
        run_frame(1'b1, 1'b0, 2'd0, 8'h81, 1'b0, 0, 1'b0);
        run_frame(1'b1, 1'b1, 2'd0, 8'h7E, 1'b0, 1, 1'b0);
        run_frame(1'b0, 1'b1, 2'd1, 8'hC3, 1'b1, 0, 1'b0);
    endtask

    task automatic test_latency();
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 3; s++) begin
                run_frame(1'(s), 1'(r), 2'(r), 8'(8'h5A + 17 * s + r),
                          1'b0, s * (1 + 11 * r) + r, 1'b0);
            end
        end
    endtask

    task automatic test_busy_write();
        run_frame(1'b1, 1'b0, 2'd1, 8'hD2, 1'b0, 2, 1'b1);
    endtask

    task automatic test_disabled();
        int starts = 0;
        @(negedge clk);
        cfg_en = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b1; cfg_rate = 2'd0;
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!ss_n || busy || sck != 1'b1) starts++;
        end
        check(starts == 0, "R2 disabled no frame", starts, 0);
        cfg_en = 1'b1; cfg_master = 1'b0;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        starts = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!ss_n || busy) starts++;
        end
        check(starts == 0, "R2 non-master no frame", starts, 0);
        cfg_master = 1'b1;
        starts = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!ss_n) starts++;
        end
        check(starts == 0, "R2 no frame without write", starts, 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_modes();
        test_latency();
        test_busy_write();
        test_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule